// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns a single-word memory-reference instruction into the final 15-bit operand address. The low ten instruction bits give a word offset inside a 1024-word page. The page-select bit picks one of two pages. When it is clear, the page is page zero. When it is set, the page is the one the program counter sits in, and the upper five address bits come from the program counter.

When the instruction's top bit is set, the formed address is not the operand. It points to a pointer word, which the block reads through a memory read port with a valid/ready request and a response one cycle later. Each pointer word carries a 15-bit address in its low bits and its own indirect flag in bit 15. The block keeps following pointers until it reads a word whose flag is clear, and that word's address is the result. The chain may have any depth.

A pointer address past the configured memory size is not sent to the port. The block treats it as a read that returned an all-zero word. The result comes out with a one-cycle done strobe, together with a flag that says the address names one of the two accumulators (addresses 0 and 1). A count of indirect words consumed is also exported, for an external interrupt unit.

The walk is a four-state machine:
- IDLE waits for a start pulse. On start it goes to DONE for a direct instruction, or to FETCH for an indirect one.
- FETCH presents the pointer address. It goes to WAIT when the port accepts, or straight to DONE when the pointer is out of range.
- WAIT takes the response. It goes back to FETCH when the word's flag is set, or to DONE when the flag is clear.
- DONE raises the strobe for one cycle and returns to IDLE.

Top module: `paged_ea_unit`

## Requirements
- R1: With instruction bit 10 at 0, the effective address of a direct instruction has bits 14..10 equal to zero and bits 9..0 equal to instruction bits 9..0.
- R2: With instruction bit 10 at 1, address bits 14..10 are copied from program counter bits 14..10, and bits 9..0 from instruction bits 9..0.
- R3: A start with instruction bit 15 at 0 raises `ea_done` in the cycle after the start edge, with no memory request and `ind_level` at 0.
- R4: A start with instruction bit 15 at 1 reads the formed address. Every returned word with bit 15 at 1 makes bits 14..0 the next read address. The first returned word with bit 15 at 0 gives `ea_addr` equal to its bits 14..0.
- R5: A pointer address not below MEM_WORDS issues no request. It is handled as a returned word of all zeros, so the walk ends with `ea_addr` equal to 0.
- R6: `acc_hit` is 1 exactly when `ea_addr` is 0 or 1.
- R7: `ind_level` is cleared on each accepted start and counts every indirect word consumed, including the zero word substituted under R5. It saturates at its all-ones value.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with an unchanged address in the next cycle.
- R9: `ea_done` is high for exactly one cycle per walk, and a start pulse that arrives while a walk is in progress is ignored.
- R10: After reset, `ea_done` and `mem_req_valid` are 0, `ea_addr` and `ind_level` are 0, and so `acc_hit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk; taken only when idle |
| instr | input | 16 | Memory-reference instruction word |
| pc | input | 15 | Program counter of the instruction |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Port accepts the request |
| mem_req_addr | output | 15 | Pointer read address |
| mem_rsp_valid | input | 1 | Read data valid, one cycle after acceptance |
| mem_rsp_data | input | 16 | Pointer word read |
| ea_addr | output | 15 | Effective address, held until the next walk |
| ea_done | output | 1 | One-cycle completion strobe |
| acc_hit | output | 1 | Effective address names an accumulator |
| ind_level | output | LVL_W | Indirect words consumed in the current walk |

## Verification
A wrong page or offset field shows up on `ea_addr` at the first done strobe. A state machine that skips or repeats a FETCH shows up in the number of accepted requests and in `ind_level` at that same strobe. Mishandling the out-of-range case shows up at once as a request issued to an address at or above the memory size, or as a nonzero result. A lost hold during a stalled request changes `mem_req_addr` in the very next cycle. A start that is not ignored while busy shows up as a second done strobe a few cycles after the first.

// File: rtl/pea_pkg.sv
package pea_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_FETCH = 2'd1,
        WS_WAIT  = 2'd2,
        WS_DONE  = 2'd3
    } walk_state_e;

    // Memory sizes the block accepts, in words.
    function automatic bit size_ok(input int unsigned words);
        return (words == 4096)  || (words == 8192)  || (words == 12288) ||
               (words == 16384) || (words == 24576) || (words == 32768);
    endfunction

endpackage

// File: rtl/pea_page_form.sv
module pea_page_form #(
    parameter int ADDR_W = 15,
    parameter int OFF_W  = 10
) (
    input  logic [ADDR_W:0]   instr,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] base_addr,
    output logic              indirect
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              cur_page;
    logic [PAGE_W-1:0] page_bits;
    logic              form_unused;

    assign cur_page  = instr[OFF_W];
    assign page_bits = cur_page ? pc[ADDR_W-1:OFF_W] : '0;
    assign base_addr = {page_bits, instr[OFF_W-1:0]};
    assign indirect  = instr[ADDR_W];

    assign form_unused = ^{instr[ADDR_W-1:OFF_W+1], pc[OFF_W-1:0]};

endmodule

// File: rtl/pea_range_gate.sv
module pea_range_gate #(
    parameter int ADDR_W    = 15,
    parameter int MEM_WORDS = 32768
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    generate
        if (MEM_WORDS >= (1 << ADDR_W)) begin : g_full
            logic addr_unused;
            assign addr_unused = ^addr;
            assign in_range    = 1'b1;
        end else begin : g_cmp
            localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_WORDS);
            assign in_range = ({1'b0, addr} < LIMIT);
        end
    endgenerate

endmodule

// File: rtl/pea_walk_fsm.sv
module pea_walk_fsm
    import pea_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              indirect,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              ptr_in_range,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W:0]   mem_rsp_data,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [ADDR_W-1:0] ea_addr,
    output logic [LVL_W-1:0]  level,
    output logic              mem_req_valid,
    output logic              done,
    output walk_state_e       state
);
    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ea_q;
    logic [LVL_W-1:0]  level_q, level_inc;
    logic              word_ind;

    assign word_ind  = mem_rsp_data[ADDR_W];
    assign level_inc = (level_q == '1) ? level_q : level_q + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (start) begin
                    state_d = indirect ? WS_FETCH : WS_DONE;
                end
            end
            WS_FETCH: begin
                if (!ptr_in_range) begin
                    state_d = WS_DONE;
                end else if (mem_req_ready) begin
                    state_d = WS_WAIT;
                end
            end
            WS_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = word_ind ? WS_FETCH : WS_DONE;
                end
            end
            WS_DONE: state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    // Pointer, result and level registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            ea_q    <= '0;
            level_q <= '0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (start) begin
                        ptr_q   <= base_addr;
                        level_q <= '0;
                        if (!indirect) begin
                            ea_q <= base_addr;
                        end
                    end
                end
                WS_FETCH: begin
                    if (!ptr_in_range) begin
                        ea_q    <= '0;
                        level_q <= level_inc;
                    end
                end
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        level_q <= level_inc;
                        if (word_ind) begin
                            ptr_q <= mem_rsp_data[ADDR_W-1:0];
                        end else begin
                            ea_q <= mem_rsp_data[ADDR_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req_valid = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            WS_FETCH: mem_req_valid = ptr_in_range;
            WS_DONE:  done          = 1'b1;
            default: ;
        endcase
    end

    assign ptr_addr = ptr_q;
    assign ea_addr  = ea_q;
    assign level    = level_q;
    assign state    = state_q;

endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit
    import pea_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int OFF_W     = 10,
    parameter int MEM_WORDS = 32768,
    parameter int LVL_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   instr,
    input  logic [ADDR_W-1:0] pc,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W:0]   mem_rsp_data,
    output logic [ADDR_W-1:0] ea_addr,
    output logic              ea_done,
    output logic              acc_hit,
    output logic [LVL_W-1:0]  ind_level
);
    localparam int ACC_LIMIT = 2;

    generate
        if (!size_ok(MEM_WORDS)) begin : g_bad_size
            $error("paged_ea_unit: MEM_WORDS must be 4K, 8K, 12K, 16K, 24K or 32K words");
        end
    endgenerate

    logic [ADDR_W-1:0] base_addr;
    logic              indirect;
    logic [ADDR_W-1:0] ptr_addr;
    logic              ptr_in_range;
    walk_state_e       walk_st;

    pea_page_form #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_form (
        .instr     (instr),
        .pc        (pc),
        .base_addr (base_addr),
        .indirect  (indirect)
    );

    pea_range_gate #(
        .ADDR_W    (ADDR_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_gate (
        .addr     (ptr_addr),
        .in_range (ptr_in_range)
    );

    pea_walk_fsm #(
        .ADDR_W (ADDR_W),
        .LVL_W  (LVL_W)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .indirect      (indirect),
        .base_addr     (base_addr),
        .ptr_in_range  (ptr_in_range),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .ptr_addr      (ptr_addr),
        .ea_addr       (ea_addr),
        .level         (ind_level),
        .mem_req_valid (mem_req_valid),
        .done          (ea_done),
        .state         (walk_st)
    );

    assign mem_req_addr = ptr_addr;
    assign acc_hit      = ({1'b0, ea_addr} < (ADDR_W + 1)'(ACC_LIMIT));

endmodule

// File: rtl/pea_walk_chk.sv
module pea_walk_chk
    import pea_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int OFF_W     = 10,
    parameter int MEM_WORDS = 32768,
    parameter int LVL_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W:0]   instr,
    input logic [ADDR_W-1:0] pc,
    input walk_state_e       st,
    input logic              ea_done,
    input logic [ADDR_W-1:0] ea_addr,
    input logic [LVL_W-1:0]  ind_level,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              accept;
    logic [ADDR_W-1:0] exp_base;
    logic              chk_unused;

    assign accept     = (st == WS_IDLE) && start;
    assign exp_base   = {(instr[OFF_W] ? pc[ADDR_W-1:OFF_W] : PAGE_W'(0)), instr[OFF_W-1:0]};
    assign chk_unused = ^pc[OFF_W-1:0];

    // R9: completion strobe lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ea_done |=> !ea_done);

    // R8: stalled request holds valid and address
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5: no request leaves for an address past the memory
    a_r5_req_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ({1'b0, mem_req_addr} < (ADDR_W + 1)'(MEM_WORDS)));

    // R3: direct instruction completes next cycle with the formed address
    a_r3_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !instr[ADDR_W]) |=> (ea_done && !mem_req_valid && (ea_addr == $past(exp_base))));

    // R7: level cleared by an accepted start
    a_r7_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ind_level == '0));

endmodule

bind paged_ea_unit pea_walk_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .MEM_WORDS (MEM_WORDS),
    .LVL_W     (LVL_W)
) u_walk_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .instr         (instr),
    .pc            (pc),
    .st            (walk_st),
    .ea_done       (ea_done),
    .ea_addr       (ea_addr),
    .ind_level     (ind_level),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_paged_ea_unit.sv
`timescale 1ns/1ps
module tb_paged_ea_unit;
    localparam int AW    = 15;
    localparam int MEMW  = 4096;
    localparam int LW    = 4;
    localparam int TABN  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW:0]   instr = '0;
    logic [AW-1:0] pc = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [AW:0]   mem_rsp_data = '0;
    logic [AW-1:0] ea_addr;
    logic          ea_done;
    logic          acc_hit;
    logic [LW-1:0] ind_level;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    int cyc = 0;
    bit stall_en = 1'b0;

    logic [AW-1:0] tab_a [TABN];
    logic [AW:0]   tab_d [TABN];
    int tab_n = 0;

    always #2.5 clk = ~clk;

    paged_ea_unit #(
        .MEM_WORDS (MEMW),
        .LVL_W     (LW)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .instr         (instr),
        .pc            (pc),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .ea_addr       (ea_addr),
        .ea_done       (ea_done),
        .acc_hit       (acc_hit),
        .ind_level     (ind_level)
    );

    function automatic logic [AW:0] lookup(input logic [AW-1:0] a);
        for (int i = 0; i < tab_n; i++) begin
            if (tab_a[i] == a) return tab_d[i];
        end
        return '0;
    endfunction

    task automatic put(input logic [AW-1:0] a, input logic [AW:0] d);
        tab_a[tab_n] = a;
        tab_d[tab_n] = d;
        tab_n++;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: one-cycle read latency, optional ready stalls
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= !stall_en || ((cyc % 3) == 0);
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= lookup(mem_req_addr);
            req_cnt       <= req_cnt + 1;
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    // R8 monitor at the falling edge
    logic          pv = 1'b0;
    logic          pr = 1'b0;
    logic [AW-1:0] pa = '0;
    always @(negedge clk) begin
        if (rst_n && pv && !pr) begin
            chk(mem_req_valid && (mem_req_addr == pa), "R8", "stalled request held",
                int'(mem_req_addr), int'(pa));
        end
        pv = mem_req_valid && rst_n;
        pr = mem_req_ready;
        pa = mem_req_addr;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc >= 150000) begin
            errors++;
            $display("FAIL watchdog run did not end");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(input logic [AW:0] ins, input logic [AW-1:0] p,
                       input logic [AW-1:0] exp_ea, input int exp_lvl,
                       input int exp_reqs, input bit poke, input string tag);
        int r0;
        int waited;
        int r1;
        @(negedge clk);
        instr = ins;
        pc    = p;
        start = 1'b1;
        r0    = req_cnt;
        @(negedge clk);
        start = 1'b0;
        if (!ins[AW]) chk(ea_done === 1'b1, "R3", {tag, " done latency"}, int'(ea_done), 1);
        waited = 0;
        while (!ea_done && waited < 500) begin
            if (poke && waited == 2) begin
                start = 1'b1;
                instr = 16'h8001;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        chk(ea_done === 1'b1, "R9", {tag, " done seen"}, int'(ea_done), 1);
        chk(ea_addr == exp_ea, (ins[AW] ? "R4" : (ins[10] ? "R2" : "R1")),
            {tag, " address"}, int'(ea_addr), int'(exp_ea));
        chk(int'(ind_level) == exp_lvl, "R7", {tag, " level"}, int'(ind_level), exp_lvl);
        chk(acc_hit == (exp_ea < 2), "R6", {tag, " accumulator flag"},
            int'(acc_hit), int'(exp_ea < 2));
        chk((req_cnt - r0) == exp_reqs, (ins[AW] ? "R5" : "R3"), {tag, " request count"},
            req_cnt - r0, exp_reqs);
        @(negedge clk);
        chk(ea_done === 1'b0, "R9", {tag, " strobe width"}, int'(ea_done), 0);
        if (poke) begin
            r1 = req_cnt;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                chk(ea_done === 1'b0, "R9", {tag, " busy start ignored"}, int'(ea_done), 0);
            end
            chk(req_cnt == r1, "R9", {tag, " no extra walk"}, req_cnt - r1, 0);
        end
    endtask

    initial begin
        // single level, current page
        put(15'h0C05, 16'h0123);
        // three levels ending on the B accumulator
        put(15'h0010, 16'h8200);
        put(15'h0200, 16'h8300);
        put(15'h0300, 16'h0001);
        // pointer held at address 0
        put(15'h0000, 16'h0777);
        // pointer leading past the memory
        put(15'h0020, 16'hF000);
        // 20-word chain for saturation
        for (int i = 0; i < 19; i++) put(15'(16'h0100 + i), 16'(16'h8101 + i));
        put(15'h0113, 16'h0055);

        repeat (3) @(negedge clk);
        chk(ea_done === 1'b0, "R10", "reset done", int'(ea_done), 0);
        chk(mem_req_valid === 1'b0, "R10", "reset request", int'(mem_req_valid), 0);
        chk(ea_addr == '0, "R10", "reset address", int'(ea_addr), 0);
        chk(ind_level == '0, "R10", "reset level", int'(ind_level), 0);
        chk(acc_hit === 1'b1, "R10", "reset accumulator flag", int'(acc_hit), 1);
        rst_n = 1'b1;

        // R1 R2 sweep over every page, both page selects, spread offsets
        for (int pg = 0; pg < 32; pg++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int off = 0; off < 1024; off += 31) begin
                    logic [AW-1:0] p;
                    logic [AW-1:0] e;
                    p = {5'(pg), 10'(pg * 7 + 3)};
                    e = {(sel != 0) ? 5'(pg) : 5'd0, 10'(off)};
                    run({1'b0, 4'(pg), 1'(sel), 10'(off)}, p, e, 0, 0, 1'b0, "direct");
                end
            end
        end
        for (int off = 0; off < 4; off++) begin
            run({6'b000000, 10'(off)}, 15'h3C00, 15'(off), 0, 0, 1'b0, "low direct");
        end

        for (int pass = 0; pass < 2; pass++) begin
            stall_en = (pass != 0);
            run(16'h8405, 15'h0C00, 15'h0123, 1, 1, 1'b0, "R4 single");
            run(16'h8010, 15'h5000, 15'h0001, 3, 3, 1'b0, "R4 chain to B");
            run(16'h8000, 15'h2345, 15'h0777, 1, 1, 1'b0, "R4 via A");
            run(16'h8020, 15'h0000, 15'h0000, 2, 1, 1'b0, "R5 mid chain");
            run(16'h8455, 15'h7C00, 15'h0000, 1, 0, 1'b0, "R5 first pointer");
            run(16'h8100, 15'h0000, 15'h0055, 15, 20, stall_en, "R7 saturation");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule